// File: doc/BRIEF.md
# Boundary Scan Data Register Chain

This block is the boundary-scan data register that sits between a chip's core-side I/O signals and its pad-side I/O signals. Each signal gets one scan cell. Pad inputs, core outputs and output enables are all separate bits of one chain. An external TAP controller drives the block with capture, shift and update strobes, a synchronous test-logic reset and the current instruction code. The block moves data serially from the test data input to the test data output.

The instruction code picks how the pads and the core are joined. With the isolate code (0), pad outputs and output enables come from the chain's update latches, and core inputs come from the input cells' latches. With the observe code (2), core and pads stay connected and the chain only watches the traffic. With any other code, the chain is bypassed: its strobes are ignored and the pads pass straight through.

Top module: `bscan_chain`

## Requirements
- R1: While `rst_n` is low, the shift stage and the update latches are all zero and `tdo` is 0.
- R2: On a rising `tck` with `capture_dr` high and the chain selected (code 0 or 2), the shift stage loads `{core_oe, core_out, pad_in}`. Bits [N_IN-1:0] hold `pad_in`, the next N_OUT bits hold `core_out`, and the top N_OE bits hold `core_oe`. This happens in both selected modes.
- R3: On a rising `tck` with `shift_dr` high, the chain selected and no capture, the stage shifts toward `tdo`. `tdo` shows bit 0, so bit 0 leaves first, and `tdi` enters at bit L-1.
- R4: On a falling `tck` with `update_dr` high and the chain selected, the update latches copy the shift stage. At no other time do the latches change, except on a reset.
- R5: With code 0, `pad_out` and `pad_oe` show the output and enable fields of the update latches, and `core_in` shows their input field.
- R6: With code 2, `pad_out` = `core_out`, `pad_oe` = `core_oe` and `core_in` = `pad_in`, while capture, shift and update still work.
- R7: With any other code, the pads pass straight through, `tdo` is 0, and the shift stage and the latches ignore all strobes.
- R8: When `tap_reset` is high at a clock edge, it clears the shift stage (rising edge) and the update latches (falling edge). It takes priority over every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tap_reset | input | 1 | Synchronous test-logic reset from the TAP |
| ir | input | IR_W | Current instruction code |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the chain) |
| pad_in | input | N_IN | Values arriving from the input pads |
| core_in | output | N_IN | Input values delivered to the core |
| core_out | input | N_OUT | Output values from the core |
| core_oe | input | N_OE | Output enables from the core |
| pad_out | output | N_OUT | Output values driven to the pads |
| pad_oe | output | N_OE | Output enables driven to the pads |

## Verification
The bench runs capture–shift–update rounds with random pad and core values and random shift-in data, under both the isolate and the observe codes. Comparing the serial stream with the captured fields shows whether the field order and the bit-0-first direction are right. Checking the pads after each update shows whether the latches or the core drive them. Directed all-ones and all-zeros patterns expose stuck or swapped bits. A bypass round under code 3, followed by reading back the old state in code 0 and code 2, shows that nothing was disturbed. A test-logic reset in the middle of a run shows that both the stage and the latches are cleared.

// File: rtl/bscan_chain.sv
`timescale 1ns/1ps
module bscan_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3,
  parameter int N_OE  = 3,
  parameter int IR_W  = 4,
  parameter logic [IR_W-1:0] IR_ISOLATE = '0,
  parameter logic [IR_W-1:0] IR_OBSERVE = IR_W'(2)
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tap_reset,
  input  logic [IR_W-1:0]  ir,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  output logic             tdo,
  input  logic [N_IN-1:0]  pad_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OE-1:0]  core_oe,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OE-1:0]  pad_oe
);
  localparam int L = N_IN + N_OUT + N_OE;

  logic [L-1:0] sr, upd;
  logic isolate, sel;

  assign isolate = (ir == IR_ISOLATE);
  assign sel     = isolate || (ir == IR_OBSERVE);

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)                 sr <= '0;
    else if (tap_reset)         sr <= '0;
    else if (sel && capture_dr) sr <= {core_oe, core_out, pad_in};
    else if (sel && shift_dr)   sr <= {tdi, sr[L-1:1]};

  always_ff @(negedge tck or negedge rst_n)
    if (!rst_n)                upd <= '0;
    else if (tap_reset)        upd <= '0;
    else if (sel && update_dr) upd <= sr;

  assign tdo     = sel & sr[0];
  assign core_in = isolate ? upd[N_IN-1:0]           : pad_in;
  assign pad_out = isolate ? upd[N_IN +: N_OUT]      : core_out;
  assign pad_oe  = isolate ? upd[N_IN+N_OUT +: N_OE] : core_oe;
endmodule

// File: rtl/bscan_chain_chk.sv
`timescale 1ns/1ps
module bscan_chain_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3,
  parameter int N_OE  = 3,
  parameter int IR_W  = 4,
  parameter logic [IR_W-1:0] IR_ISOLATE = '0,
  parameter logic [IR_W-1:0] IR_OBSERVE = IR_W'(2),
  localparam int L = N_IN + N_OUT + N_OE
) (
  input logic            tck,
  input logic            rst_n,
  input logic            tap_reset,
  input logic [IR_W-1:0] ir,
  input logic            capture_dr,
  input logic            shift_dr,
  input logic            update_dr,
  input logic            tdi,
  input logic            tdo,
  input logic [L-1:0]    sr,
  input logic [L-1:0]    upd
);
  logic on;
  assign on = (ir == IR_ISOLATE) || (ir == IR_OBSERVE);

  // R3
  shift_dir_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (on && shift_dr && !capture_dr && !tap_reset) |=>
      (sr[L-1] == $past(tdi)) && (sr[L-2:0] == $past(sr[L-1:1])));

  // R4
  latch_hold_chk: assert property (@(negedge tck) disable iff (!rst_n)
    (!update_dr && !tap_reset) |=> $stable(upd));

  // R7
  bypass_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (!on && !tap_reset) |=> $stable(sr));

  // R7
  bypass_tdo_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !on |-> (tdo == 1'b0));

  // R8
  tlr_clear_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tap_reset |=> (sr == '0));
endmodule

bind bscan_chain bscan_chain_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .N_OE(N_OE), .IR_W(IR_W),
  .IR_ISOLATE(IR_ISOLATE), .IR_OBSERVE(IR_OBSERVE)
) chk_i (
  .tck(tck), .rst_n(rst_n), .tap_reset(tap_reset), .ir(ir),
  .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
  .tdi(tdi), .tdo(tdo), .sr(sr), .upd(upd)
);

// File: tb/bscan_chain_tb.sv
`timescale 1ns/1ps
module bscan_chain_tb_top;
  localparam int N_IN = 4, N_OUT = 3, N_OE = 3, IR_W = 4;
  localparam int L = N_IN + N_OUT + N_OE;

  logic tck = 1'b0;
  always #2.5 tck = ~tck;

  logic rst_n, tap_reset, capture_dr, shift_dr, update_dr, tdi, tdo;
  logic [IR_W-1:0]  ir;
  logic [N_IN-1:0]  pad_in, core_in;
  logic [N_OUT-1:0] core_out, pad_out;
  logic [N_OE-1:0]  core_oe, pad_oe;

  bscan_chain #(.N_IN(N_IN), .N_OUT(N_OUT), .N_OE(N_OE), .IR_W(IR_W)) dut_i (
    .tck(tck), .rst_n(rst_n), .tap_reset(tap_reset), .ir(ir),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo), .pad_in(pad_in), .core_in(core_in),
    .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string r, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic tick();
    @(posedge tck); #1;
  endtask

  function automatic logic [L-1:0] cap_vec(logic [N_IN-1:0] pi, logic [N_OUT-1:0] co,
                                           logic [N_OE-1:0] oe);
    return {oe, co, pi};
  endfunction

  task automatic check_pads(string r, logic [L-1:0] lat);
    if (ir == '0) begin
      chk(r, 32'(pad_out), 32'(lat[N_IN +: N_OUT]));
      chk(r, 32'(pad_oe),  32'(lat[N_IN+N_OUT +: N_OE]));
      chk(r, 32'(core_in), 32'(lat[N_IN-1:0]));
    end else begin
      chk(r, 32'(pad_out), 32'(core_out));
      chk(r, 32'(pad_oe),  32'(core_oe));
      chk(r, 32'(core_in), 32'(pad_in));
    end
  endtask

  task automatic shift_all(string r, logic [L-1:0] expv, logic [L-1:0] din);
    for (int i = 0; i < L; i++) begin
      chk(r, 32'(tdo), 32'(expv[i]));
      tdi = din[i]; shift_dr = 1'b1; tick();
    end
    shift_dr = 1'b0; tdi = 1'b0;
  endtask

  task automatic round(string r, logic [L-1:0] din);
    logic [L-1:0] c;
    c = cap_vec(pad_in, core_out, core_oe);
    capture_dr = 1'b1; tick(); capture_dr = 1'b0;
    shift_all(r, c, din);
    update_dr = 1'b1; tick(); update_dr = 1'b0;
    check_pads(r, din);
  endtask

  initial begin
    logic [L-1:0] d1;
    void'($urandom(32'd1234));
    rst_n = 0; tap_reset = 0; capture_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
    ir = '0; pad_in = 4'h9; core_out = 3'h5; core_oe = 3'h6;
    #1;
    chk("R1 tdo in reset", 32'(tdo), 0);
    chk("R1 pad_out in reset", 32'(pad_out), 0);
    chk("R1 core_in in reset", 32'(core_in), 0);
    tick(); rst_n = 1; tick();

    // R2 R3 R4 R5 directed corners in isolate mode
    ir = '0; pad_in = '1; core_out = '1; core_oe = '1;
    round("R2 R3 R4 R5 ones", '0);
    pad_in = '0; core_out = '0; core_oe = '0;
    round("R2 R3 R4 R5 zeros", '1);

    // R6 observe mode with passthrough
    for (int k = 0; k < 12; k++) begin
      ir = ($urandom % 2) ? IR_W'(2) : '0;
      pad_in = N_IN'($urandom); core_out = N_OUT'($urandom); core_oe = N_OE'($urandom);
      round(ir == '0 ? "R2 R3 R5 random isolate" : "R2 R3 R6 random observe", L'($urandom));
    end

    // R7 bypass: load known latches first
    ir = '0; d1 = L'(10'h2B5);
    round("R5 preload", d1);
    ir = IR_W'(3);
    pad_in = 4'h3; core_out = 3'h2; core_oe = 3'h1;
    #0.5;
    chk("R7 pad_out passthrough", 32'(pad_out), 32'(core_out));
    chk("R7 pad_oe passthrough", 32'(pad_oe), 32'(core_oe));
    chk("R7 core_in passthrough", 32'(core_in), 32'(pad_in));
    capture_dr = 1; tick(); capture_dr = 0;
    for (int i = 0; i < 4; i++) begin
      chk("R7 tdo zero", 32'(tdo), 0);
      tdi = 1; shift_dr = 1; tick();
    end
    shift_dr = 0; tdi = 0;
    update_dr = 1; tick(); update_dr = 0;
    ir = '0; #0.5;
    check_pads("R7 latches untouched", d1);
    ir = IR_W'(2);
    shift_all("R7 stage untouched", d1, '0);

    // R8 test-logic reset clears stage and latches
    ir = '0;
    round("R5 preload2", L'(10'h3CF));
    tap_reset = 1; capture_dr = 1; update_dr = 1; tick();
    tap_reset = 0; capture_dr = 0; update_dr = 0;
    check_pads("R8 latches cleared", '0);
    shift_all("R8 stage cleared", '0, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule